// File: doc/BRIEF.md
# Synchronous Serial Transmitter with Tail Mark

This block sends one data word from a small register file over two lines: a shift clock and a serial data line. The word is 8 or 16 bits long and goes out least significant bit first. Software loads the data bytes and picks the word length, the clock rate and the marker options. It then writes a start bit. When the last data bit has gone out, the start flag drops and a completion interrupt flag rises.

When mark mode is on, the block follows every word with an end-of-frame marker on both lines. The marker has a fixed four-unit clock shape. In the hold variant the data line keeps the last bit. In the latch variant the data line is driven high while the clock is low, which signals a latch event. A busy flag reads 1 for the whole marker. The control register cannot be rewritten until the block is idle again. Software sends words back to back by reloading the data and setting the start bit after each completion.

Top module: `sync_tail_tx`

## Requirements
- R1: The time unit U is 2^(sel+1) system clocks, where sel is control bits 6:4. Each data bit cell holds the shift clock low for U clocks and then high for U clocks.
- R2: In 8-bit mode (control bit 0 = 0), only the lower data byte (address 0) is sent, bit 0 first. The data line changes only where the shift clock falls.
- R3: In 16-bit mode (control bit 0 = 1), the lower byte is sent as bits 0..7 and then the upper byte (address 1) as bits 8..15.
- R4: Writing 1 to status bit 0 (address 3) while the block is idle starts a word. In the next clock the shift clock is low and the data line carries bit 0. Status bit 0 reads 1 until the word completes.
- R5: On the clock edge that ends the last data bit, status bit 0 clears and the interrupt flag (status bit 2 and the irq port) sets. Writing 1 to status bit 2 clears the flag. If that write falls on the completion edge, the flag still sets.
- R6: With mark mode off (control bit 1 = 0), the block goes idle straight after the data bits. The shift clock idles high and the data line keeps the last bit.
- R7: With mark mode on and the hold marker chosen (control bit 2 = 0), the marker is U clocks of clock high, 2U low and U high. The data line holds the last data bit throughout and afterwards.
- R8: With the latch marker chosen (control bit 2 = 1), the clock shape is the same. The data line holds the last bit for the first U clocks, then reads high from the low pulse onwards, and stays high in idle.
- R9: Status bit 1 reads 1 exactly during the marker and never together with status bit 0.
- R10: A write to the control register (address 2) or to the start bit is ignored while a word or a marker is in progress. The data bytes can be written at any time.
- R11: After reset, the shift clock and the data line are high, all flags are 0 and the control register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address: 0 low byte, 1 high byte, 2 control, 3 status |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the register at addr |
| sck | output | 1 | Shift clock output |
| sdo | output | 1 | Serial data output |
| irq | output | 1 | Completion interrupt flag |

## Verification
The completion of a word and a software clear of the interrupt flag can land on the same clock edge. The bench provokes this by timing the clear write so that it is sampled on the exact edge that ends the last data bit of an 8-bit word. It then expects the flag to read 1 afterwards. Attempts to rewrite the control register and to restart during a word and during a marker are judged the same way: the control readback and the line waveform must stay unchanged.

// File: rtl/sync_tail_tx.sv
module sync_tail_tx #(
  parameter int SEL_W = 3,
  parameter int CNT_W = 1 << SEL_W
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       sck,
  output logic       sdo,
  output logic       irq
);
  typedef enum logic [1:0] {S_IDLE, S_DATA, S_TAIL} state_t;

  state_t             state;
  logic [7:0]         dlo, dhi;
  logic               wide, mark_en, latch_sel;
  logic [SEL_W-1:0]   csel;
  logic               start_f, irq_f, last_q;
  logic [5:0]         ph;
  logic [CNT_W-1:0]   pcnt, lim;
  logic [15:0]        word;

  wire idle  = (state == S_IDLE);
  wire busy  = (state == S_TAIL);
  wire go    = wr_en && addr == 2'd3 && wdata[0] && idle;
  wire clr   = wr_en && addr == 2'd3 && wdata[2];
  wire tick  = (pcnt == lim);
  wire [5:0] last_ph = wide ? 6'd31 : 6'd15;
  wire lowp  = (ph == 6'd1) || (ph == 6'd2);

  assign lim = {CNT_W{1'b1}} >> (CNT_W - 1 - int'(csel));
  assign irq = irq_f;

  always_comb begin
    case (state)
      S_DATA:  begin sck = ph[0];  sdo = word[ph[4:1]]; end
      S_TAIL:  begin sck = !lowp;  sdo = (latch_sel && ph != 6'd0) ? 1'b1 : last_q; end
      default: begin sck = 1'b1;   sdo = last_q; end
    endcase
  end

  always_comb begin
    case (addr)
      2'd0:    rdata = dlo;
      2'd1:    rdata = dhi;
      2'd2:    rdata = {1'b0, 3'(csel), 1'b0, latch_sel, mark_en, wide};
      default: rdata = {5'd0, irq_f, busy, start_f};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dlo <= '0; dhi <= '0;
      wide <= 1'b0; mark_en <= 1'b0; latch_sel <= 1'b0; csel <= '0;
    end else if (wr_en) begin
      if (addr == 2'd0) dlo <= wdata;
      if (addr == 2'd1) dhi <= wdata;
      if (addr == 2'd2 && idle) begin
        wide      <= wdata[0];
        mark_en   <= wdata[1];
        latch_sel <= wdata[2];
        csel      <= wdata[4 +: SEL_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; ph <= '0; pcnt <= '0; word <= '0;
      start_f <= 1'b0; irq_f <= 1'b0; last_q <= 1'b1;
    end else begin
      last_q <= sdo;
      if (clr) irq_f <= 1'b0;
      if (go) begin
        state   <= S_DATA;
        ph      <= '0;
        pcnt    <= '0;
        word    <= {wide ? dhi : 8'h00, dlo};
        start_f <= 1'b1;
      end else if (!idle) begin
        pcnt <= tick ? '0 : pcnt + 1'b1;
        if (tick) begin
          if (state == S_DATA && ph == last_ph) begin
            start_f <= 1'b0;
            irq_f   <= 1'b1;
            state   <= mark_en ? S_TAIL : S_IDLE;
            ph      <= '0;
          end else if (state == S_TAIL && ph == 6'd3) begin
            state <= S_IDLE;
            ph    <= '0;
          end else begin
            ph <= ph + 1'b1;
          end
        end
      end
    end
  end

  assert_done_sets_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(start_f) |-> irq_f);

  assert_ctrl_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(idle) |-> $stable({wide, mark_en, latch_sel, csel}));

  assert_busy_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start_f);

  assert_cell_steady_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DATA && $past(state == S_DATA) && !$past(tick)) |-> $stable(sck));

  assert_idle_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> sck);
endmodule

// File: tb/sync_tail_tx_tb.sv
module sync_tail_tx_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [1:0] addr = 2'd3;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       sck, sdo, irq;

  int tests = 0, fails = 0, cyc = 0;

  sync_tail_tx dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .sck(sck), .sdo(sdo), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct packed {
    logic sck; logic sdo; logic busy; logic start; logic last;
    logic [3:0] tck; logic [3:0] tdo;
  } ent_t;

  ent_t q[$];
  logic [7:0] m_lo = 0, m_hi = 0, m_ctrl = 0;
  logic m_irq = 0, m_sdo = 1'b1;
  logic [3:0] m_itag = 4'd11;

  function automatic string tg(input logic [3:0] c);
    case (c)
      4'd1: return "R1";  4'd2: return "R2";  4'd3: return "R3";
      4'd4: return "R4";  4'd5: return "R5";  4'd6: return "R6";
      4'd7: return "R7";  4'd8: return "R8";  4'd9: return "R9";
      4'd10: return "R10"; default: return "R11";
    endcase
  endfunction

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input logic [3:0] t, input string what);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s cycle %0d: actual %h expected %h", tg(t), what, cyc, act, exp);
    end
  endtask

  task automatic push_frame();
    int u, n;
    logic [15:0] w;
    logic lb, lt;
    u = 1 << (int'(m_ctrl[6:4]) + 1);
    n = m_ctrl[0] ? 16 : 8;
    w = {m_ctrl[0] ? m_hi : 8'h00, m_lo};
    for (int i = 0; i < n; i++)
      for (int h = 0; h < 2; h++)
        for (int k = 0; k < u; k++)
          q.push_back('{h[0], w[i], 1'b0, 1'b1, (i == n-1 && h == 1 && k == u-1),
                        4'd1, (i >= 8) ? 4'd3 : 4'd2});
    lb = w[n-1];
    lt = m_ctrl[2];
    m_sdo = lb; m_itag = 4'd6;
    if (m_ctrl[1]) begin
      for (int k = 0; k < u; k++)   q.push_back('{1'b1, lb, 1'b1, 1'b0, 1'b0, 4'd7, 4'd7});
      for (int k = 0; k < 2*u; k++) q.push_back('{1'b0, lt ? 1'b1 : lb, 1'b1, 1'b0, 1'b0, 4'd7, lt ? 4'd8 : 4'd7});
      for (int k = 0; k < u; k++)   q.push_back('{1'b1, lt ? 1'b1 : lb, 1'b1, 1'b0, 1'b0, 4'd7, lt ? 4'd8 : 4'd7});
      m_sdo = lt ? 1'b1 : lb;
      m_itag = lt ? 4'd8 : 4'd7;
    end
  endtask

  always @(posedge clk) begin
    logic was_idle, set_irq;
    ent_t e;
    cyc++;
    if (rst_n) begin
      was_idle = (q.size() == 0);
      set_irq = 1'b0;
      if (!was_idle) begin
        e = q.pop_front();
        set_irq = e.last;
      end
      if (wr_en) begin
        if (addr == 2'd0) m_lo = wdata;
        if (addr == 2'd1) m_hi = wdata;
        if (addr == 2'd2 && was_idle) m_ctrl = wdata & 8'h77;
        if (addr == 2'd3 && wdata[2]) m_irq = 1'b0;
        if (addr == 2'd3 && wdata[0] && was_idle) push_frame();
      end
      if (set_irq) m_irq = 1'b1;
    end
  end

  always @(negedge clk) begin
    ent_t e;
    if (rst_n) begin
      if (q.size() != 0) e = q[0];
      else e = '{1'b1, m_sdo, 1'b0, 1'b0, 1'b0, 4'd6, m_itag};
      chk({7'd0, sck}, {7'd0, e.sck}, e.tck, "sck");
      chk({7'd0, sdo}, {7'd0, e.sdo}, e.tdo, "sdo");
      chk({7'd0, irq}, {7'd0, m_irq}, 4'd5, "irq port");
      case (addr)
        2'd0: chk(rdata, m_lo, 4'd10, "low byte");
        2'd1: chk(rdata, m_hi, 4'd10, "high byte");
        2'd2: chk(rdata, m_ctrl, 4'd10, "control");
        default: begin
          chk({7'd0, rdata[0]}, {7'd0, e.start}, 4'd4, "start flag");
          chk({7'd0, rdata[1]}, {7'd0, e.busy}, 4'd9, "busy flag");
          chk({7'd0, rdata[2]}, {7'd0, m_irq}, 4'd5, "irq flag");
        end
      endcase
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 1'b0; addr = 2'd3; wdata = '0;
  endtask

  task automatic wait_idle();
    while (q.size() != 0) @(posedge clk);
    repeat (4) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk({6'd0, sck, sdo}, 8'h03, 4'd11, "reset lines");
    chk({7'd0, irq}, 8'h00, 4'd11, "reset irq");
    chk(rdata, 8'h00, 4'd11, "reset status");
    rst_n = 1'b1;

    // R2 R6: 8-bit, fastest unit, no marker
    wr(2'd0, 8'hA5); wr(2'd2, 8'h00); wr(2'd3, 8'h01);
    wait_idle();
    wr(2'd3, 8'h04);

    // R3 R7 R9 R10: 16-bit, hold marker, lock tests mid-word and mid-marker
    wr(2'd0, 8'h5A); wr(2'd1, 8'hC3); wr(2'd2, 8'h13); wr(2'd3, 8'h01);
    repeat (10) @(posedge clk);
    wr(2'd2, 8'h76); wr(2'd3, 8'h01);
    addr = 2'd2; repeat (3) @(posedge clk); #1; addr = 2'd3;
    while (!(q.size() != 0 && q[0].busy)) @(posedge clk);
    wr(2'd2, 8'h00); wr(2'd3, 8'h01);
    wait_idle();

    // R5 R8: 8-bit latch marker, clear written on the completion edge
    wr(2'd0, 8'h34); wr(2'd2, 8'h06); wr(2'd3, 8'h05);
    repeat (30) @(posedge clk);
    wr(2'd3, 8'h04);
    wait_idle();
    wr(2'd3, 8'h04);

    // R1 R7: slower unit, hold marker with last bit 0, back to back words
    wr(2'd0, 8'h6B); wr(2'd2, 8'h22); wr(2'd3, 8'h01);
    wait_idle();
    wr(2'd0, 8'h81); wr(2'd3, 8'h05);
    wait_idle();
    addr = 2'd0; @(posedge clk); #1; addr = 2'd1; @(posedge clk); #1; addr = 2'd3;
    repeat (4) @(posedge clk);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL R11 watchdog expired: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule